// File: doc/BRIEF.md
# Byte-Serial Credit-Flow Link Port

This block is one end of a synchronous, full-duplex switch link. Each direction moves one byte per clock over a parallel byte bus. A side-band control flag separates control symbols from data bytes. Flow control works on two-byte flow units. The transmitter holds one credit for each flow unit the far end can still buffer. It spends a credit on the first byte of every unit. The far end hands credits back as token symbols once its buffer drains.

On the transmit side, the block takes packets byte by byte from a local valid/ready source. The first bytes of a packet are its route bytes, and every byte is carried through unchanged. The block frames each packet with a begin symbol and an end symbol. A packet with an odd byte count gets a pad symbol, so that it ends on a whole flow unit.

On the receive side, incoming bytes are assembled into flow units and held in a FIFO. The FIFO depth in units equals the credit count loaded at reset. The units are presented to a local valid/ready sink one byte at a time, with first and last markers. Each time a unit leaves the FIFO, a token goes back on the outbound link. Both directions run at the same time and share the outbound link for data and tokens.

Top module: `flow_link_port`

## Requirements
- R1: After reset the outbound link carries no symbol (`lnk_tx_vld`=0), `out_valid` is 0, and `in_ready` is 0 while `in_valid` is 0.
- R2: A data byte travels with `ctl`=0. Control symbols travel with `ctl`=1 and use these codes: begin 0x01, end 0x02, token 0x03, pad 0x04.
- R3: The credit counter is loaded with FIFO_FLITS at reset. A new flow unit starts only when the counter is nonzero, and the counter drops by one on the unit's first byte. With no tokens returned, exactly FIFO_FLITS units are sent and then the port stalls.
- R4: Every token received adds one credit. A token that arrives in the same cycle as a unit's first byte is not lost, so the count stays unchanged in that cycle.
- R5: A packet is sent as a begin symbol, then every payload byte in input order (route bytes first, unchanged), then an end symbol.
- R6: When a packet ends on the first byte of a flow unit, a pad symbol fills the unit, and the end symbol follows in the next cycle.
- R7: Received data is buffered as flow units, up to FIFO_FLITS of them. It is delivered in order, one byte per `out_valid`/`out_ready` handshake. `out_first` is set on a packet's first byte and `out_last` on its last byte, and pad symbols are never delivered.
- R8: Exactly one token is sent for each flow unit that leaves the receive FIFO, padded units included. No token is sent while the FIFO is not draining.
- R9: Pending tokens are sent only between flow units, where they take priority over starting a new unit. A token never falls between the two bytes of one unit.
- R10: Transmit and receive operate at the same time. A port looped back on itself delivers every packet intact under random backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Local transmit byte valid |
| in_data | input | 8 | Local transmit byte |
| in_last | input | 1 | Byte is the last of its packet |
| in_ready | output | 1 | Port accepts the transmit byte |
| out_valid | output | 1 | Received byte valid |
| out_data | output | 8 | Received byte |
| out_first | output | 1 | Byte is the first of its packet |
| out_last | output | 1 | Byte is the last of its packet |
| out_ready | input | 1 | Local sink accepts the received byte |
| lnk_tx_vld | output | 1 | Outbound symbol present |
| lnk_tx_ctl | output | 1 | Outbound symbol is a control symbol |
| lnk_tx_data | output | 8 | Outbound byte or control code |
| lnk_rx_vld | input | 1 | Inbound symbol present |
| lnk_rx_ctl | input | 1 | Inbound symbol is a control symbol |
| lnk_rx_data | input | 8 | Inbound byte or control code |

## Verification
Two pairs of events can fall in the same cycle. A token can arrive in the same cycle that the transmitter spends a credit. A unit can leave the receive FIFO while a newly assembled unit is written into it. The first case is provoked on purpose: the bench times an injected token to meet the first byte of the fourth unit. It then judges the outcome by counting data bytes, expecting five units to pass before the stall rather than four. The second case arises in loopback under random `out_ready` backpressure, and it is judged by comparing every delivered byte and marker against a queue the bench builds from what it sent.

// File: rtl/flink_pkg.sv
// Shared symbol codes, the transmit state type and the buffered flow-unit
// record for the byte-serial credit-flow link port.
package flink_pkg;
    localparam logic [7:0] SYM_BEGIN = 8'h01;
    localparam logic [7:0] SYM_END   = 8'h02;
    localparam logic [7:0] SYM_TOKEN = 8'h03;
    localparam logic [7:0] SYM_PAD   = 8'h04;

    typedef enum logic [2:0] {
        TX_IDLE, TX_GAP, TX_SECOND, TX_PAD, TX_END
    } tx_st_e;

    // One flow unit as held in the receive FIFO.
    typedef struct packed {
        logic [7:0] b0;
        logic [7:0] b1;
        logic       first;
        logic       last;
        logic       odd;    // only b0 carries data, b1 was a pad
    } flit_t;
endpackage

// File: rtl/flink_fifo.sv
// Circular FIFO of DEPTH entries with read-first output (rdata shows the
// head entry). Assumes the caller never writes when full or reads when empty.
module flink_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [W-1:0]    mem [DEPTH];
    logic [PW-1:0]   wp, rp;
    logic [CNTW-1:0] cnt;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (cnt == CNTW'(DEPTH));
    assign empty = (cnt == '0);
    assign rdata = mem[rp];

    // Storage write.
    always_ff @(posedge clk) begin
        if (wr) mem[wp] <= wdata;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr) wp <= step(wp);
            if (rd) rp <= step(rp);
            case ({wr, rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: ;
            endcase
        end
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> !full);
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd |-> !empty);
endmodule

// File: rtl/flink_tx.sv
// Transmit framer. It frames local bytes with begin/end symbols, pads an
// odd packet to a whole flow unit, spends one credit per unit and inserts
// pending return tokens at unit boundaries. Link outputs are combinational
// from state and in_data. It assumes the far end returns no more tokens
// than units it was sent.
module flink_tx
    import flink_pkg::*;
#(
    parameter int CRED_MAX = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    input  logic       tok_rx,     // a token arrived from the far end
    input  logic       tok_req,    // local FIFO freed one unit
    output logic       lnk_vld,
    output logic       lnk_ctl,
    output logic [7:0] lnk_data
);
    localparam int CW = $clog2(CRED_MAX + 1);
    localparam int TW = CW + 1;

    tx_st_e        st, st_nx;
    logic [CW-1:0] credit;
    logic [TW-1:0] tok_pend;
    logic          send_tok, start_unit;

    // A token may only go out where no unit is open.
    assign send_tok   = (tok_pend != '0) && (st == TX_IDLE || st == TX_GAP);
    assign start_unit = (st == TX_GAP) && !send_tok && (credit != '0) && in_valid;
    assign in_ready   = ((st == TX_GAP) && !send_tok && (credit != '0)) ||
                        (st == TX_SECOND);

    // Symbol selection for the outbound link.
    always_comb begin
        lnk_vld  = 1'b0;
        lnk_ctl  = 1'b0;
        lnk_data = '0;
        if (send_tok) begin
            lnk_vld = 1'b1; lnk_ctl = 1'b1; lnk_data = SYM_TOKEN;
        end else begin
            case (st)
                TX_IDLE:   if (in_valid) begin
                               lnk_vld = 1'b1; lnk_ctl = 1'b1; lnk_data = SYM_BEGIN;
                           end
                TX_GAP:    if (start_unit) begin
                               lnk_vld = 1'b1; lnk_data = in_data;
                           end
                TX_SECOND: if (in_valid) begin
                               lnk_vld = 1'b1; lnk_data = in_data;
                           end
                TX_PAD:    begin lnk_vld = 1'b1; lnk_ctl = 1'b1; lnk_data = SYM_PAD; end
                TX_END:    begin lnk_vld = 1'b1; lnk_ctl = 1'b1; lnk_data = SYM_END; end
                default:   ;
            endcase
        end
    end

    // Next framing state.
    always_comb begin
        st_nx = st;
        case (st)
            TX_IDLE:   if (!send_tok && in_valid) st_nx = TX_GAP;
            TX_GAP:    if (start_unit) st_nx = in_last ? TX_PAD : TX_SECOND;
            TX_SECOND: if (in_valid)   st_nx = in_last ? TX_END : TX_GAP;
            TX_PAD:    st_nx = TX_END;
            TX_END:    st_nx = TX_IDLE;
            default:   st_nx = TX_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= st_nx;
    end

    // Credit counter: loaded full at reset, +1 per token, -1 per unit start.
    always_ff @(posedge clk) begin
        if (!rst_n) credit <= CW'(CRED_MAX);
        else case ({tok_rx, start_unit})
            2'b10:   credit <= credit + 1'b1;
            2'b01:   credit <= credit - 1'b1;
            default: ;
        endcase
    end

    // Count of tokens owed to the far end.
    always_ff @(posedge clk) begin
        if (!rst_n) tok_pend <= '0;
        else case ({tok_req, send_tok})
            2'b10:   tok_pend <= tok_pend + 1'b1;
            2'b01:   tok_pend <= tok_pend - 1'b1;
            default: ;
        endcase
    end

    p_credit_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        credit <= CW'(CRED_MAX));
    p_unit_atomic_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_SECOND) |-> !(lnk_vld && lnk_ctl));
    p_pad_then_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_vld && lnk_ctl && lnk_data == SYM_PAD) |=>
        (lnk_vld && lnk_ctl && lnk_data == SYM_END));
endmodule

// File: rtl/flink_rx.sv
// Receive side. It decodes inbound symbols, assembles byte pairs into flow
// units, keeps the newest unit staged until the next unit or the end symbol
// settles its last flag, buffers units in a FIFO and drains them byte-wise.
// Each unit leaving the FIFO raises tok_req. It assumes the far end obeys
// the credits, so the FIFO cannot overflow.
module flink_rx
    import flink_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lnk_vld,
    input  logic       lnk_ctl,
    input  logic [7:0] lnk_data,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_first,
    output logic       out_last,
    input  logic       out_ready,
    output logic       tok_seen,
    output logic       tok_req
);
    localparam int FW = $bits(flit_t);

    logic       is_data, is_begin, is_end, is_pad;
    logic       half, sop_pend, hold_sop, stg_v, sel;
    logic [7:0] hold_b0;
    flit_t      stg, wflit, cur;
    logic       push, pop, acc, full, empty;
    logic [FW-1:0] rdata;

    assign is_data  = lnk_vld && !lnk_ctl;
    assign is_begin = lnk_vld && lnk_ctl && (lnk_data == SYM_BEGIN);
    assign is_end   = lnk_vld && lnk_ctl && (lnk_data == SYM_END);
    assign is_pad   = lnk_vld && lnk_ctl && (lnk_data == SYM_PAD);
    assign tok_seen = lnk_vld && lnk_ctl && (lnk_data == SYM_TOKEN);

    // The staged unit is released by the end symbol or by a following unit.
    always_comb begin
        wflit = stg;
        push  = 1'b0;
        if (is_end && stg_v) begin
            push       = 1'b1;
            wflit.last = 1'b1;
        end else if (is_data && !half && stg_v) begin
            push = 1'b1;
        end
    end

    // Assembly of byte pairs into the staging register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half     <= 1'b0;
            sop_pend <= 1'b0;
            hold_sop <= 1'b0;
            hold_b0  <= '0;
            stg_v    <= 1'b0;
            stg      <= '0;
        end else begin
            if (is_begin) sop_pend <= 1'b1;
            if (is_data && !half) begin
                hold_b0  <= lnk_data;
                hold_sop <= sop_pend;
                sop_pend <= 1'b0;
                half     <= 1'b1;
                stg_v    <= 1'b0;
            end else if ((is_data || is_pad) && half) begin
                stg   <= '{b0: hold_b0, b1: is_pad ? 8'h00 : lnk_data,
                           first: hold_sop, last: 1'b0, odd: is_pad};
                stg_v <= 1'b1;
                half  <= 1'b0;
            end else if (is_end) begin
                stg_v <= 1'b0;
            end
        end
    end

    flink_fifo #(.DEPTH(DEPTH), .W(FW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr(push), .wdata(wflit),
        .rd(pop), .rdata(rdata), .full(full), .empty(empty)
    );

    assign cur       = flit_t'(rdata);
    assign out_valid = !empty;
    assign out_data  = sel ? cur.b1 : cur.b0;
    assign out_first = cur.first && !sel;
    assign out_last  = cur.last && (sel || cur.odd);
    assign acc       = out_valid && out_ready;
    assign pop       = acc && (sel || cur.odd);
    assign tok_req   = pop;

    // Byte select within the head unit.
    always_ff @(posedge clk) begin
        if (!rst_n)   sel <= 1'b0;
        else if (pop) sel <= 1'b0;
        else if (acc) sel <= 1'b1;
    end

    p_pad_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_pad |-> half);
    p_full_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> !empty);
endmodule

// File: rtl/flow_link_port.sv
// Top of the byte-serial credit-flow link port. It joins the transmit
// framer and the receive buffer: tokens decoded from the inbound link feed
// the transmit credits, and units drained locally queue tokens outbound.
// FIFO_FLITS sets both the receive depth and the reset credit count, so
// both ends must use the same value.
module flow_link_port #(
    parameter int FIFO_FLITS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_first,
    output logic       out_last,
    input  logic       out_ready,
    output logic       lnk_tx_vld,
    output logic       lnk_tx_ctl,
    output logic [7:0] lnk_tx_data,
    input  logic       lnk_rx_vld,
    input  logic       lnk_rx_ctl,
    input  logic [7:0] lnk_rx_data
);
    logic tok_seen, tok_req;

    flink_tx #(.CRED_MAX(FIFO_FLITS)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .tok_rx(tok_seen), .tok_req(tok_req),
        .lnk_vld(lnk_tx_vld), .lnk_ctl(lnk_tx_ctl), .lnk_data(lnk_tx_data)
    );

    flink_rx #(.DEPTH(FIFO_FLITS)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .lnk_vld(lnk_rx_vld), .lnk_ctl(lnk_rx_ctl), .lnk_data(lnk_rx_data),
        .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
        .out_last(out_last), .out_ready(out_ready),
        .tok_seen(tok_seen), .tok_req(tok_req)
    );
endmodule

// File: tb/tb_flow_link_port.sv
// Self-checking bench: directed credit, padding and receive cases, then a
// seeded random loopback run.
module tb_flow_link_port;
    localparam int DEPTH = 4;
    localparam logic [8:0] C_BEGIN = 9'h101, C_END = 9'h102,
                           C_TOKEN = 9'h103, C_PAD = 9'h104;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, in_valid, in_last, in_ready, out_valid, out_first, out_last, out_ready;
    logic [7:0] in_data, out_data, lnk_tx_data, lnk_rx_data, drv_data;
    logic lnk_tx_vld, lnk_tx_ctl, lnk_rx_vld, lnk_rx_ctl, drv_vld, drv_ctl, loop;

    assign lnk_rx_vld  = loop ? lnk_tx_vld  : drv_vld;
    assign lnk_rx_ctl  = loop ? lnk_tx_ctl  : drv_ctl;
    assign lnk_rx_data = loop ? lnk_tx_data : drv_data;

    flow_link_port #(.FIFO_FLITS(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid),
        .out_data(out_data), .out_first(out_first), .out_last(out_last),
        .out_ready(out_ready), .lnk_tx_vld(lnk_tx_vld), .lnk_tx_ctl(lnk_tx_ctl),
        .lnk_tx_data(lnk_tx_data), .lnk_rx_vld(lnk_rx_vld),
        .lnk_rx_ctl(lnk_rx_ctl), .lnk_rx_data(lnk_rx_data)
    );

    int nchk = 0, nfail = 0;
    logic [8:0] tx_log[$];
    logic [9:0] out_log[$];
    logic [9:0] exp_q[$];
    logic [7:0] sent_q[$];
    int data_cnt, tok_cnt, lb_cred, lb_par, lb_beats;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [9:0] beat(input bit f, input bit l, input logic [7:0] d);
        return {f, l, d};
    endfunction

    // Link and output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (lnk_tx_vld) begin
                tx_log.push_back({lnk_tx_ctl, lnk_tx_data});
                if (!lnk_tx_ctl) data_cnt++;
                if ({lnk_tx_ctl, lnk_tx_data} == C_TOKEN) tok_cnt++;
                if (loop) begin
                    if (!lnk_tx_ctl) begin
                        if (lb_par == 0) begin
                            chk(lb_cred > 0, "R3", "unit start credit", lb_cred, 1);
                            lb_cred--;
                        end
                        lb_par ^= 1;
                    end else if ({lnk_tx_ctl, lnk_tx_data} == C_PAD) begin
                        chk(lb_par == 1, "R6", "pad position", lb_par, 1);
                        lb_par = 0;
                    end else if ({lnk_tx_ctl, lnk_tx_data} == C_END) begin
                        chk(lb_par == 0, "R6", "end on unit boundary", lb_par, 0);
                    end else if ({lnk_tx_ctl, lnk_tx_data} == C_TOKEN) begin
                        chk(lb_par == 0, "R9", "token inside unit", lb_par, 0);
                        lb_cred++;
                    end
                end
            end
            if (out_valid && out_ready) begin
                out_log.push_back(beat(out_first, out_last, out_data));
                if (loop) begin
                    lb_beats++;
                    if (exp_q.size() == 0)
                        chk(1'b0, "R10", "unexpected beat", int'(out_data), 0);
                    else begin
                        logic [9:0] e;
                        e = exp_q.pop_front();
                        chk(beat(out_first, out_last, out_data) == e, "R7",
                            "loopback beat", int'(beat(out_first, out_last, out_data)), int'(e));
                    end
                end
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
        drv_vld = 1'b0; drv_ctl = 1'b0; drv_data = '0; out_ready = 1'b0; loop = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tx_log.delete(); out_log.delete(); exp_q.delete(); sent_q.delete();
        data_cnt = 0; tok_cnt = 0; lb_cred = DEPTH; lb_par = 0; lb_beats = 0;
    endtask

    // Sends one packet through the local transmit interface.
    task automatic send_pkt(input int len, input bit rnd);
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            if (rnd && $urandom_range(3) == 0) begin
                in_valid = 1'b0;
                repeat ($urandom_range(2, 1)) @(posedge clk);
                #1;
            end
            b = rnd ? 8'($urandom) : 8'(i * 17 + 3);
            sent_q.push_back(b);
            exp_q.push_back(beat(i == 0, i == len - 1, b));
            in_valid = 1'b1; in_data = b; in_last = (i == len - 1);
            forever begin @(negedge clk); if (in_ready) break; end
            @(posedge clk); #1;
        end
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    // Drives one inbound symbol for one cycle.
    task automatic rx_sym(input logic [8:0] s);
        drv_vld = 1'b1; drv_ctl = s[8]; drv_data = s[7:0];
        @(posedge clk); #1;
        drv_vld = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R10 watchdog: got %0d cycles expected completion", 150000);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        // R1: reset state
        do_reset();
        @(negedge clk);
        chk(!lnk_tx_vld, "R1", "lnk_tx_vld", lnk_tx_vld, 0);
        chk(!out_valid, "R1", "out_valid", out_valid, 0);
        chk(!in_ready, "R1", "in_ready", in_ready, 0);

        // R6 / R2 / R5: three-byte packet is padded
        do_reset();
        send_pkt(3, 1'b0);
        repeat (5) @(posedge clk);
        chk(tx_log.size() == 6, "R6", "odd packet symbol count", tx_log.size(), 6);
        if (tx_log.size() == 6) begin
            chk(tx_log[0] == C_BEGIN, "R2", "begin code", tx_log[0], C_BEGIN);
            for (int i = 0; i < 3; i++)
                chk(tx_log[i+1] == {1'b0, sent_q[i]}, "R5", "payload byte",
                    tx_log[i+1], {1'b0, sent_q[i]});
            chk(tx_log[4] == C_PAD, "R6", "pad symbol", tx_log[4], C_PAD);
            chk(tx_log[5] == C_END, "R6", "end after pad", tx_log[5], C_END);
        end

        // R3 / R4: credit exhaustion, token in same cycle as unit start
        do_reset();
        fork send_pkt(12, 1'b0); join_none
        while (data_cnt < 6) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        drv_vld = 1'b1; drv_ctl = 1'b1; drv_data = C_TOKEN[7:0];
        @(posedge clk); #1;
        drv_vld = 1'b0;
        repeat (30) @(posedge clk);
        chk(data_cnt == 10, "R4", "bytes sent with same-cycle token", data_cnt, 10);
        @(negedge clk);
        chk(!in_ready, "R3", "stalled without credit", in_ready, 0);
        @(posedge clk); #1;
        rx_sym(C_TOKEN);
        wait fork;
        repeat (5) @(posedge clk);
        chk(data_cnt == 12, "R3", "bytes after extra token", data_cnt, 12);
        chk(tx_log.size() == 14, "R5", "even packet symbol count", tx_log.size(), 14);
        if (tx_log.size() == 14) begin
            chk(tx_log[0] == C_BEGIN, "R5", "begin first", tx_log[0], C_BEGIN);
            chk(tx_log[13] == C_END, "R5", "end last, no pad", tx_log[13], C_END);
            for (int i = 0; i < 12; i++)
                chk(tx_log[i+1] == {1'b0, sent_q[i]}, "R5", "payload order",
                    tx_log[i+1], {1'b0, sent_q[i]});
        end
        chk(tok_cnt == 0, "R8", "no token without receive", tok_cnt, 0);

        // R7 / R8: padded packet received
        do_reset();
        out_ready = 1'b1;
        @(posedge clk); #1;
        rx_sym(C_BEGIN); rx_sym(9'h0A1); rx_sym(9'h0B2); rx_sym(9'h0C3);
        rx_sym(C_PAD); rx_sym(C_END);
        repeat (10) @(posedge clk);
        chk(out_log.size() == 3, "R7", "beats delivered", out_log.size(), 3);
        if (out_log.size() == 3) begin
            chk(out_log[0] == beat(1, 0, 8'hA1), "R7", "first beat", out_log[0], beat(1, 0, 8'hA1));
            chk(out_log[1] == beat(0, 0, 8'hB2), "R7", "middle beat", out_log[1], beat(0, 0, 8'hB2));
            chk(out_log[2] == beat(0, 1, 8'hC3), "R7", "last beat", out_log[2], beat(0, 1, 8'hC3));
        end
        chk(tok_cnt == 2, "R8", "tokens for two units", tok_cnt, 2);

        // R7 / R8: full FIFO held back, then drained
        do_reset();
        @(posedge clk); #1;
        rx_sym(C_BEGIN);
        for (int i = 0; i < 8; i++) rx_sym({1'b0, 8'(8'h40 + i)});
        rx_sym(C_END);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(out_valid, "R7", "data held while stalled", out_valid, 1);
        chk(tok_cnt == 0, "R8", "no token while stalled", tok_cnt, 0);
        @(posedge clk); #1;
        out_ready = 1'b1;
        repeat (20) @(posedge clk);
        chk(out_log.size() == 8, "R7", "full FIFO drained", out_log.size(), 8);
        if (out_log.size() == 8)
            for (int i = 0; i < 8; i++)
                chk(out_log[i] == beat(i == 0, i == 7, 8'(8'h40 + i)), "R7",
                    "drained beat", out_log[i], beat(i == 0, i == 7, 8'(8'h40 + i)));
        chk(tok_cnt == 4, "R8", "one token per unit", tok_cnt, 4);

        // R10: random loopback, both directions at once
        do_reset();
        loop = 1'b1;
        begin
            bit lb_run;
            int total;
            lb_run = 1'b1;
            total = 0;
            fork
                begin
                    for (int p = 0; p < 40; p++) begin
                        int n;
                        n = $urandom_range(9, 1);
                        total += n;
                        send_pkt(n, 1'b1);
                    end
                    lb_run = 1'b0;
                end
                begin
                    while (lb_run) begin
                        @(posedge clk); #1;
                        out_ready = ($urandom_range(3) != 0);
                    end
                    out_ready = 1'b1;
                end
            join
            for (int k = 0; k < 500 && exp_q.size() != 0; k++) @(posedge clk);
            repeat (5) @(posedge clk);
            chk(exp_q.size() == 0, "R10", "loopback undelivered", exp_q.size(), 0);
            chk(lb_beats == total, "R10", "loopback beat count", lb_beats, total);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule